// File: doc/BRIEF.md
# System-Control Coprocessor Status and Exception Unit

This unit holds the machine-control state of a small 32-bit RISC core: a mode/status word, an exception-cause word, the exception return address and a fixed processor-identity word. The pipeline reaches these through a register-access port. It gives a five-bit index, a valid strobe, a write flag and write data, and it gets read data back in the same cycle. The port works only while the status word marks kernel mode. In user mode reads return zero and writes are dropped.

The unit also decides when a trap is taken. It takes a trap for a syscall request, or for a hardware interrupt line that both its own mask bit and the global enable allow. On entry it pushes the two-bit mode/enable pair onto a three-level stack in the status word and records the cause code, the delay-slot flag and the return address. It then pulses a trap indication with the code, one cycle later, to the fetch logic. A return-from-exception strobe pops the stack by one level.

Top module: `sysctl_cop`

## Requirements
- R1: After reset the status word reads 0x00000002 (kernel mode, interrupts off, all masks clear), cause and return address read 0, and `trap_taken` is 0.
- R2: Index 12 reads the stored status word ANDed with 0x0000FF3F. A write to index 12 stores the write data ANDed with 0x0003FF3F.
- R3: Index 15 reads the constant `PRID`. Any index other than 12, 13, 14 and 15 reads 0.
- R4: While status bit 1 is 0 (user mode), `acc_rdata` is 0, writes are ignored and the return-from-exception strobe has no effect.
- R5: A return-from-exception in kernel mode loads status bits 3:0 from the old bits 5:2 and leaves bits 31:4 unchanged.
- R6: On trap entry, status bits 5:0 become {old bits 3:0, 1, 0}. The old pair moves up one level, and the unit enters kernel mode with the global enable (bit 0) cleared. Bits 31:6 stay unchanged.
- R7: Interrupt line i causes a trap only when status bit 0 is 1 and status bit 8+i is 1. A masked or disabled line causes no trap.
- R8: The cycle after a trap condition, `trap_taken` is 1 for one cycle and `trap_code` is 8 for a syscall or 0 for an interrupt. Index 13 shows that code in bits 6:2.
- R9: On trap entry, index 14 takes `flt_pc`, or `flt_pc`−4 when `flt_in_slot` is 1. Cause bit 31 takes `flt_in_slot`.
- R10: Cause bits 15:8 show the current interrupt lines, line i at bit 8+i, whether or not they are masked.
- R11: Priority order in one cycle: a syscall request comes before an interrupt, any trap comes before a return-from-exception, and a return-from-exception comes before a status write. The actions that lose are dropped.
- R12: Writes to indices 13, 14, 15 and any unimplemented index leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 5 | Register index |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data (combinational) |
| rfe_req | input | 1 | Return-from-exception strobe |
| exc_req | input | 1 | Syscall exception request |
| flt_pc | input | 32 | Address of the instruction being trapped |
| flt_in_slot | input | 1 | That instruction sits in a branch delay slot |
| irq | input | NIRQ | Hardware interrupt lines |
| trap_taken | output | 1 | One-cycle trap pulse to fetch |
| trap_code | output | 5 | Cause code of the trap just taken |

## Verification
The bench builds the unit with six interrupt lines, direct interrupt sampling (no synchronizer stages), a four-byte slot back-off and the default identity word. With direct sampling, a line's effect on the cause word and on trap entry falls in the same cycle. Every priority collision, such as a syscall together with an interrupt or a write together with a trap, can then be forced in a single chosen cycle. Six lines are enough to cover masked and unmasked lines at once and to show that the unused cause bits 15:14 read zero.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   localparam logic [4:0]  IDX_STATUS   = 5'd12;
   localparam logic [4:0]  IDX_CAUSE    = 5'd13;
   localparam logic [4:0]  IDX_EPC      = 5'd14;
   localparam logic [4:0]  IDX_PRID     = 5'd15;
   localparam logic [31:0] STAT_RD_MASK = 32'h0000_FF3F;
   localparam logic [31:0] STAT_WR_MASK = 32'h0003_FF3F;
   localparam logic [31:0] STAT_RESET   = 32'h0000_0002;
   localparam logic [4:0]  CODE_INT     = 5'd0;
   localparam logic [4:0]  CODE_SYS     = 5'd8;

   typedef struct packed {
      logic       bd;
      logic [4:0] code;
   } cause_t;
endpackage

// File: rtl/sysctl_irq_gate.sv
module sysctl_irq_gate #(
   parameter int unsigned NIRQ = 6
) (
   input  logic [NIRQ-1:0] irq_seen,
   input  logic [NIRQ-1:0] mask,
   input  logic            gie,
   output logic            int_req
);
   logic [NIRQ-1:0] pend;

   always_comb begin
      pend    = irq_seen & mask;
      int_req = gie & (|pend);
   end
endmodule

// File: rtl/sysctl_status_reg.sv
module sysctl_status_reg
   import sysctl_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        trap_fire,
   input  logic        pop,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] st_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= STAT_RESET;
      end else if (trap_fire) begin
         st_q[5:0] <= {st_q[3:0], 2'b10};
      end else if (pop) begin
         st_q[3:0] <= st_q[5:2];
      end else if (wr_en) begin
         st_q <= wr_data & STAT_WR_MASK;
      end
   end
endmodule

// File: rtl/sysctl_trap_ctl.sv
module sysctl_trap_ctl
   import sysctl_pkg::*;
#(
   parameter int unsigned SLOT_BACK = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sys_req,
   input  logic        int_req,
   input  logic [31:0] flt_pc,
   input  logic        flt_in_slot,
   output logic        trap_fire,
   output cause_t      cause_q,
   output logic [31:0] epc_q,
   output logic        trap_taken,
   output logic [4:0]  trap_code
);
   localparam logic [31:0] BACK = 32'(SLOT_BACK);

   logic [4:0]  code_n;
   logic [31:0] epc_n;

   always_comb begin
      trap_fire = sys_req | int_req;
      code_n    = sys_req ? CODE_SYS : CODE_INT;
      epc_n     = flt_in_slot ? (flt_pc - BACK) : flt_pc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q    <= '0;
         epc_q      <= '0;
         trap_taken <= 1'b0;
         trap_code  <= '0;
      end else begin
         trap_taken <= trap_fire;
         if (trap_fire) begin
            cause_q.bd   <= flt_in_slot;
            cause_q.code <= code_n;
            epc_q        <= epc_n;
            trap_code    <= code_n;
         end
      end
   end
endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
   import sysctl_pkg::*;
#(
   parameter int unsigned NIRQ        = 6,
   parameter int unsigned SYNC_STAGES = 0,
   parameter int unsigned SLOT_BACK   = 4,
   parameter logic [31:0] PRID        = 32'h0000_0230
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            acc_valid,
   input  logic            acc_write,
   input  logic [4:0]      acc_idx,
   input  logic [31:0]     acc_wdata,
   output logic [31:0]     acc_rdata,
   input  logic            rfe_req,
   input  logic            exc_req,
   input  logic [31:0]     flt_pc,
   input  logic            flt_in_slot,
   input  logic [NIRQ-1:0] irq,
   output logic            trap_taken,
   output logic [4:0]      trap_code
);
   localparam int unsigned MASK_LO = 8;

   if (NIRQ < 1 || NIRQ > 8) begin : g_bad_nirq
      $error("sysctl_cop: NIRQ must be 1..8");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("sysctl_cop: SYNC_STAGES must be 0..4");
   end
   if (SLOT_BACK == 0) begin : g_bad_back
      $error("sysctl_cop: SLOT_BACK must be nonzero");
   end

   logic [NIRQ-1:0] irq_seen;
   logic [31:0]     st_q;
   logic            kern;
   logic            int_req;
   logic            trap_fire;
   cause_t          cause_q;
   logic [31:0]     epc_q;
   logic            wr_en;
   logic            pop;
   logic [7:0]      irq8;

   if (SYNC_STAGES == 0) begin : g_direct
      assign irq_seen = irq;
   end else begin : g_sync
      logic [NIRQ-1:0] chain [SYNC_STAGES];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int k = 0; k < int'(SYNC_STAGES); k++) chain[k] <= '0;
         end else begin
            chain[0] <= irq;
            for (int k = 1; k < int'(SYNC_STAGES); k++) chain[k] <= chain[k-1];
         end
      end
      assign irq_seen = chain[SYNC_STAGES-1];
   end

   assign kern  = st_q[1];
   assign pop   = rfe_req & kern;
   assign wr_en = acc_valid & acc_write & kern & (acc_idx == IDX_STATUS);

   sysctl_irq_gate #(.NIRQ(NIRQ)) u_gate (
      .irq_seen (irq_seen),
      .mask     (st_q[MASK_LO +: NIRQ]),
      .gie      (st_q[0]),
      .int_req  (int_req)
   );

   sysctl_status_reg u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .trap_fire (trap_fire),
      .pop       (pop),
      .wr_en     (wr_en),
      .wr_data   (acc_wdata),
      .st_q      (st_q)
   );

   sysctl_trap_ctl #(.SLOT_BACK(SLOT_BACK)) u_trap (
      .clk         (clk),
      .rst_n       (rst_n),
      .sys_req     (exc_req),
      .int_req     (int_req),
      .flt_pc      (flt_pc),
      .flt_in_slot (flt_in_slot),
      .trap_fire   (trap_fire),
      .cause_q     (cause_q),
      .epc_q       (epc_q),
      .trap_taken  (trap_taken),
      .trap_code   (trap_code)
   );

   always_comb begin
      irq8                 = '0;
      irq8[NIRQ-1:0]       = irq_seen;
   end

   always_comb begin
      acc_rdata = '0;
      if (acc_valid && kern) begin
         case (acc_idx)
            IDX_STATUS: acc_rdata = st_q & STAT_RD_MASK;
            IDX_CAUSE:  acc_rdata = {cause_q.bd, 15'd0, irq8, 1'b0, cause_q.code, 2'b00};
            IDX_EPC:    acc_rdata = epc_q;
            IDX_PRID:   acc_rdata = PRID;
            default:    acc_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/sysctl_cop_chk.sv
module sysctl_cop_chk #(
   parameter int unsigned NIRQ = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            exc_req,
   input logic            rfe_req,
   input logic            flt_in_slot,
   input logic            trap_taken,
   input logic [4:0]      trap_code,
   input logic [31:0]     st_q,
   input logic            trap_fire,
   input logic [NIRQ-1:0] irq_seen,
   input logic [5:0]      cause_bits
);
   p_sys_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |=> (trap_taken && trap_code == 5'd8));

   p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!exc_req && !(st_q[0] && |(irq_seen & st_q[8 +: NIRQ]))) |=> !trap_taken);

   p_entry_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_taken |-> (st_q[1:0] == 2'b10));

   p_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rfe_req && st_q[1] && !trap_fire) |=> (st_q[3:0] == $past(st_q[5:2])));

   p_user_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_q[1] && !trap_fire) |=> $stable(st_q));

   p_slot_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_taken |-> (cause_bits[5] == $past(flt_in_slot)));
endmodule

bind sysctl_cop sysctl_cop_chk #(.NIRQ(NIRQ)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .exc_req     (exc_req),
   .rfe_req     (rfe_req),
   .flt_in_slot (flt_in_slot),
   .trap_taken  (trap_taken),
   .trap_code   (trap_code),
   .st_q        (st_q),
   .trap_fire   (trap_fire),
   .irq_seen    (irq_seen),
   .cause_bits  (cause_q)
);

// File: tb/sysctl_cop_bench.sv
module sysctl_cop_bench;
   localparam int unsigned NIRQ = 6;
   localparam logic [31:0] PRID = 32'h0000_0230;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            acc_valid = 1'b0;
   logic            acc_write = 1'b0;
   logic [4:0]      acc_idx = '0;
   logic [31:0]     acc_wdata = '0;
   logic [31:0]     acc_rdata;
   logic            rfe_req = 1'b0;
   logic            exc_req = 1'b0;
   logic [31:0]     flt_pc = '0;
   logic            flt_in_slot = 1'b0;
   logic [NIRQ-1:0] irq = '0;
   logic            trap_taken;
   logic [4:0]      trap_code;

   always #10 clk = ~clk;

   sysctl_cop #(.NIRQ(NIRQ), .SYNC_STAGES(0), .SLOT_BACK(4), .PRID(PRID)) u_sysctl_cop (
      .clk (clk), .rst_n (rst_n), .acc_valid (acc_valid), .acc_write (acc_write),
      .acc_idx (acc_idx), .acc_wdata (acc_wdata), .acc_rdata (acc_rdata),
      .rfe_req (rfe_req), .exc_req (exc_req), .flt_pc (flt_pc),
      .flt_in_slot (flt_in_slot), .irq (irq), .trap_taken (trap_taken),
      .trap_code (trap_code)
   );

   int unsigned n_chk = 0;
   int unsigned n_err = 0;

   logic [31:0] m_st;
   logic        m_bd;
   logic [4:0]  m_code;
   logic [31:0] m_epc;
   logic        m_trap;
   logic [4:0]  m_tcode;
   logic [31:0] last_rd;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic v, input logic [4:0] ix,
                                          input logic [NIRQ-1:0] iq);
      logic [7:0] i8;
      i8 = '0;
      i8[NIRQ-1:0] = iq;
      if (!v || !m_st[1]) return 32'h0;
      case (ix)
         5'd12:   return m_st & 32'h0000_FF3F;
         5'd13:   return {m_bd, 15'd0, i8, 1'b0, m_code, 2'b00};
         5'd14:   return m_epc;
         5'd15:   return PRID;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string rd_tag(input logic [4:0] ix);
      if (!m_st[1]) return "R4";
      case (ix)
         5'd12:   return "R2";
         5'd13:   return "R10";
         5'd14:   return "R9";
         default: return "R3";
      endcase
   endfunction

   // One cycle: drive after the falling edge, check, advance model, reach next falling edge.
   task automatic step(input logic ex, input logic slot, input logic rf,
                       input logic v, input logic w, input logic [4:0] ix,
                       input logic [31:0] wd, input logic [31:0] pc,
                       input logic [NIRQ-1:0] iq);
      logic take_int, take;
      exc_req = ex; flt_in_slot = slot; rfe_req = rf; acc_valid = v;
      acc_write = w; acc_idx = ix; acc_wdata = wd; flt_pc = pc; irq = iq;
      #1;
      last_rd = acc_rdata;
      chk(rd_tag(ix), acc_rdata, exp_rd(v, ix, iq));
      chk("R8", {31'd0, trap_taken}, {31'd0, m_trap});
      if (m_trap) chk("R8", {27'd0, trap_code}, {27'd0, m_tcode});
      take_int = m_st[0] && |(iq & m_st[8 +: NIRQ]);
      take     = ex || take_int;
      m_trap   = take;
      if (take) begin
         m_tcode   = ex ? 5'd8 : 5'd0;
         m_code    = m_tcode;
         m_bd      = slot;
         m_epc     = slot ? pc - 32'd4 : pc;
         m_st[5:0] = {m_st[3:0], 2'b10};
      end else if (rf && m_st[1]) begin
         m_st[3:0] = m_st[5:2];
      end else if (v && w && m_st[1] && ix == 5'd12) begin
         m_st = wd & 32'h0003_FF3F;
      end
      @(negedge clk);
   endtask

   task automatic rd(input logic [4:0] ix, input string tag, input logic [31:0] exp);
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, ix, 32'h0, 32'h0, irq);
      chk(tag, last_rd, exp);
   endtask

   task automatic wr(input logic [4:0] ix, input logic [31:0] d);
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, ix, d, 32'h0, irq);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_st = 32'h2; m_bd = 0; m_code = 0; m_epc = 0; m_trap = 0; m_tcode = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1", {31'd0, trap_taken}, 32'd0);
      // R1 reset values
      rd(5'd12, "R1", 32'h0000_0002);
      rd(5'd13, "R1", 32'h0000_0000);
      rd(5'd14, "R1", 32'h0000_0000);
      // R3 identity and unimplemented index
      rd(5'd15, "R3", PRID);
      rd(5'd7,  "R3", 32'h0);
      // R2 masks
      wr(5'd12, 32'hFFFF_FFFF);
      rd(5'd12, "R2", 32'h0000_FF3F);
      // R12 writes elsewhere ignored
      wr(5'd13, 32'hFFFF_FFFF);
      wr(5'd14, 32'h1234_5678);
      wr(5'd15, 32'hFFFF_FFFF);
      wr(5'd20, 32'hFFFF_FFFF);
      rd(5'd13, "R12", 32'h0);
      rd(5'd14, "R12", 32'h0);
      rd(5'd12, "R12", 32'h0000_FF3F);
      // R5 pop: 5:0 = 100110 -> 101001 (user mode after pop)
      wr(5'd12, 32'h0000_0F26);
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, '0);
      // R4 user mode: reads zero, write and rfe ignored
      rd(5'd12, "R4", 32'h0);
      wr(5'd12, 32'h0000_0002);
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, '0);
      // R6 syscall re-enters kernel: 101001 -> 100110
      step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0000_1000, '0);
      rd(5'd12, "R6", 32'h0000_0F26);
      rd(5'd14, "R9", 32'h0000_1000);
      rd(5'd13, "R8", 32'h0000_0020);
      // R5 pop from kernel with bits 5:2 = 1011: 101110 -> 101011
      wr(5'd12, 32'h0000_002E);
      step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, '0);
      rd(5'd12, "R5", 32'h0000_002B);
      // R7/R10 masked line, then unmasked line
      wr(5'd12, 32'h0000_0403);
      irq = 6'b000010;
      rd(5'd13, "R10", 32'h0000_0220);
      chk("R7", {31'd0, trap_taken}, 32'd0);
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0000_3000, 6'b000100);
      chk("R8", {31'd0, trap_taken}, 32'd1);
      chk("R8", {27'd0, trap_code}, 32'd0);
      // line still high but global enable now clear: no new trap
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0, 6'b000100);
      chk("R7", {31'd0, trap_taken}, 32'd0);
      rd(5'd12, "R6", 32'h0000_040E);
      // R9 delay slot
      irq = '0;
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0, 32'h0, 32'h0000_2000, '0);
      rd(5'd14, "R9", 32'h0000_1FFC);
      rd(5'd13, "R9", 32'h8000_0020);
      // R11 syscall beats interrupt; trap beats write and rfe
      wr(5'd12, 32'h0000_3F03);
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 5'd12, 32'h0000_0002, 32'h0000_4000, 6'b111111);
      chk("R11", {27'd0, trap_code}, 32'd8);
      irq = '0;
      rd(5'd12, "R11", 32'h0000_3F0E);
      // R11 rfe beats write
      step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 5'd12, 32'h0000_0002, 32'h0, '0);
      rd(5'd12, "R11", 32'h0000_3F03);

      // constrained random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         int unsigned r;
         logic [4:0]  ix;
         logic [31:0] wd;
         logic [NIRQ-1:0] iq;
         r  = $urandom % 100;
         case ($urandom % 5)
            0: ix = 5'd12;
            1: ix = 5'd13;
            2: ix = 5'd14;
            3: ix = 5'd15;
            default: ix = 5'($urandom);
         endcase
         wd = $urandom;
         if (($urandom % 10) != 0) wd[1] = 1'b1;
         iq = (($urandom % 4) == 0) ? NIRQ'($urandom) : '0;
         step(r < 5, 1'($urandom), (r >= 5 && r < 12), 1'b1, (r >= 75),
              ix, wd, $urandom & 32'hFFFF_FFFC, iq);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule